// File: doc/BRIEF.md
# Handshaked Register-Bus Peripheral Slave

This block is a slave on an 8-bit special-function-register bus. It holds two registers at fixed direct addresses in the upper half of the address space: a control register and a data register. The CPU side presents an address, a mode flag that marks indirect accesses, and separate read and write strobes. The block answers each accepted strobe with an acknowledge that rises when the access is served. The acknowledge stays up until the bus controller removes the strobe. The shared data bus is driven by the block only while an acknowledged read is in progress.

Behind the registers, the block can take over one general-purpose pin. A select output tells the pin multiplexer that the peripheral owns the pin. When both the select bit and the drive-enable bit are set, the block drives the pin with a bit of the data register. In every other case it leaves the pin floating and samples the pin level so software can read it back.

Top module: `sfr_bus_slave`

## Requirements
- R1: While rst_n is 0 at a rising clock edge, ack and pin_sel become 0 and both registers clear. After reset, a read of the control register returns 0 in bits 6:0 and a read of the data register returns 0x00.
- R2: A write strobe whose rising edge is first sampled at clock edge N, with addr_bus equal to the control address (default 0x98) or the data address (default 0x99) and indirect_sel 0, stores data_bus into that register at edge N. ack is 1 after edge N.
- R3: A read strobe accepted under the same address conditions at edge N drives the addressed register onto data_bus from edge N on, and ack rises at the same edge.
- R4: Once raised, ack stays 1 at every edge where the strobe is still sampled high. At the first edge where both strobes are sampled low, ack falls and data_bus is released.
- R5: A write strobe held high for several cycles stores exactly once. A later change of data_bus while the strobe is still high is not stored.
- R6: A strobe at any other address leaves both registers unchanged, gives no ack, and leaves data_bus undriven.
- R7: A strobe with indirect_sel 1 is ignored, even at a register address: no ack, no register change, and data_bus stays undriven.
- R8: pin_sel equals control bit 0.
- R9: pin_io is driven with data register bit 0 only when control bits 1 and 0 are both 1. Otherwise pin_io is high-impedance.
- R10: Control bit 7 reads the level of pin_io, sampled one clock earlier. Writes to control bit 7 have no effect.
- R11: data_bus is never driven outside an acknowledged read of a matching direct address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_bus | input | 8 | Register address, valid with the strobe |
| indirect_sel | input | 1 | 1 marks an indirect access, which is ignored |
| data_bus | inout | 8 | Shared data bus, driven only during an acknowledged read |
| rd_stb | input | 1 | CPU read strobe |
| wr_stb | input | 1 | CPU write strobe |
| ack | output | 1 | Four-phase acknowledge |
| pin_sel | output | 1 | 1 hands the general-purpose pin to the peripheral |
| pin_io | inout | 1 | Pin data line, driven or sampled by the peripheral |

## Verification
A wrong internal state shows at the ports within one clock edge of the next access:
- A corrupted register or a wrongly decoded address shows up on the next read-back of either register.
- A stuck or early-dropped acknowledge shows up in the cycle that follows a strobe edge.
- An unwanted bus drive is caught by probing the bus with a value the bench drives itself and checking that this value survives.
- Pin ownership errors show on pin_sel and pin_io right after a control write, and in control bit 7 one edge after the pin level changes.

// File: rtl/sfr_slave_pkg.sv
// Shared types and bit positions for the register-bus slave.
// Assumes a single control and a single data register.
package sfr_slave_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    localparam int CTRL_PSEL_BIT = 0;   // pin ownership
    localparam int CTRL_OE_BIT   = 1;   // pin drive enable
    localparam int CTRL_PIN_BIT  = 7;   // read-only pin level
    localparam int DATA_PIN_BIT  = 0;   // value driven onto the pin
endpackage

// File: rtl/sfr_addr_decode.sv
// Address decoder: maps a direct-mode address to one of the two registers.
// Treats indirect_sel as an extra address bit; indirect accesses never hit.
module sfr_addr_decode
    import sfr_slave_pkg::*;
#(
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   CTRL_ADDR = 8'h98,
    parameter logic [AW-1:0]   DATA_ADDR = 8'h99
) (
    input  logic [AW-1:0] addr,
    input  logic          indirect,
    output reg_sel_e      hit_sel
);
    // Full decode of {indirect, address}, with indirect required to be 0.
    localparam logic [AW:0] CTRL_KEY = {1'b0, CTRL_ADDR};
    localparam logic [AW:0] DATA_KEY = {1'b0, DATA_ADDR};

    // Select the addressed register, or none.
    always_comb begin
        if ({indirect, addr} == CTRL_KEY)      hit_sel = SEL_CTRL;
        else if ({indirect, addr} == DATA_KEY) hit_sel = SEL_DATA;
        else                                   hit_sel = SEL_NONE;
    end
endmodule

// File: rtl/sfr_handshake.sv
// Strobe edge detector and four-phase acknowledge controller.
// Assumes strobes are synchronous to clk. A strobe is accepted on its first
// sampled high level. ack is held until both strobes are sampled low.
// If both strobes rise together, the write wins.
module sfr_handshake
    import sfr_slave_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_stb,
    input  logic     wr_stb,
    input  reg_sel_e hit_sel,
    output logic     wr_take,
    output reg_sel_e wr_sel,
    output logic     ack,
    output logic     rd_drive,
    output reg_sel_e rd_sel
);
    logic     rd_prev_q, wr_prev_q, ack_q, rd_act_q;
    reg_sel_e rd_sel_q;
    logic     rd_rise, wr_rise, hit, rd_take;

    // Edge detection against the previous sampled strobe and acceptance.
    always_comb begin
        rd_rise = rd_stb & ~rd_prev_q;
        wr_rise = wr_stb & ~wr_prev_q;
        hit     = (hit_sel != SEL_NONE);
        wr_take = wr_rise & hit & ~ack_q;
        rd_take = rd_rise & hit & ~ack_q & ~wr_stb;
    end

    // Strobe history, acknowledge and read-session state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b0;
            wr_prev_q <= 1'b0;
            ack_q     <= 1'b0;
            rd_act_q  <= 1'b0;
            rd_sel_q  <= SEL_NONE;
        end else begin
            rd_prev_q <= rd_stb;
            wr_prev_q <= wr_stb;
            if (ack_q) begin
                if (!rd_stb && !wr_stb) begin
                    ack_q    <= 1'b0;
                    rd_act_q <= 1'b0;
                end
            end else if (wr_take) begin
                ack_q <= 1'b1;
            end else if (rd_take) begin
                ack_q    <= 1'b1;
                rd_act_q <= 1'b1;
                rd_sel_q <= hit_sel;
            end
        end
    end

    assign wr_sel   = hit_sel;
    assign ack      = ack_q;
    assign rd_drive = ack_q & rd_act_q;
    assign rd_sel   = rd_sel_q;

    // R3: an accepted read raises ack and drives the bus at the same edge.
    a_r3_read_ack_drive: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> (ack_q && rd_drive));
    // R4: ack holds while a strobe is still high.
    a_r4_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && (rd_stb || wr_stb)) |=> ack_q);
    // R4: ack falls and the bus is released once both strobes are low.
    a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !rd_stb && !wr_stb) |=> (!ack_q && !rd_drive));
    // R5: a held write strobe yields a single store pulse.
    a_r5_single_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !wr_take);
    // R6: a strobe edge at a non-matching address raises no ack.
    a_r6_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_rise || wr_rise) && (hit_sel == SEL_NONE) && !ack_q) |=> !ack_q);
endmodule

// File: rtl/sfr_regs.sv
// Control and data registers plus pin ownership logic.
// Assumes wr_take is a single-cycle pulse. pin_in is synchronised by one flop.
module sfr_regs
    import sfr_slave_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_take,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wdata,
    input  reg_sel_e      rd_sel,
    input  logic          pin_in,
    output logic [DW-1:0] rdata,
    output logic          pin_sel,
    output logic          pin_oe,
    output logic          pin_out
);
    localparam int CW = CTRL_PIN_BIT;   // stored control bits below the pin bit

    logic [CW-1:0] ctrl_q;
    logic [DW-1:0] data_q;
    logic          pin_q;

    // Register stores on the accepted write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else if (wr_take) begin
            if (wr_sel == SEL_CTRL)      ctrl_q <= wdata[CW-1:0];
            else if (wr_sel == SEL_DATA) data_q <= wdata;
        end
    end

    // Sample the pin level for read-back.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_in;
    end

    // Read mux: the control view carries the sampled pin in its top bit.
    always_comb begin
        if (rd_sel == SEL_DATA) rdata = data_q;
        else                    rdata = {{(DW-CW){pin_q}}, ctrl_q};
    end

    assign pin_sel = ctrl_q[CTRL_PSEL_BIT];
    assign pin_oe  = ctrl_q[CTRL_PSEL_BIT] & ctrl_q[CTRL_OE_BIT];
    assign pin_out = data_q[DATA_PIN_BIT];

    // R10: a control write stores the low bits only.
    a_r10_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && wr_sel == SEL_CTRL) |=> (ctrl_q == $past(wdata[CW-1:0])));
    // R9: the pin is never driven without ownership.
    a_r9_drive_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> pin_sel);
endmodule

// File: rtl/sfr_bus_slave.sv
// Top of the register-bus slave: decoder, handshake, registers and the
// tri-state drivers for the shared data bus and the general-purpose pin.
// Assumes addr_bus and indirect_sel are stable while a strobe is high.
module sfr_bus_slave
    import sfr_slave_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h98,
    parameter logic [AW-1:0] DATA_ADDR = 8'h99
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_bus,
    input  logic          indirect_sel,
    inout  wire  [DW-1:0] data_bus,
    input  logic          rd_stb,
    input  logic          wr_stb,
    output logic          ack,
    output logic          pin_sel,
    inout  wire           pin_io
);
    reg_sel_e      hit_sel, wr_sel, rd_sel;
    logic          wr_take, rd_drive;
    logic [DW-1:0] rdata;
    logic          pin_oe, pin_out;

    sfr_addr_decode #(.AW(AW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)) u_dec (
        .addr     (addr_bus),
        .indirect (indirect_sel),
        .hit_sel  (hit_sel)
    );

    sfr_handshake u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .hit_sel  (hit_sel),
        .wr_take  (wr_take),
        .wr_sel   (wr_sel),
        .ack      (ack),
        .rd_drive (rd_drive),
        .rd_sel   (rd_sel)
    );

    sfr_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_take (wr_take),
        .wr_sel  (wr_sel),
        .wdata   (data_bus),
        .rd_sel  (rd_sel),
        .pin_in  (pin_io),
        .rdata   (rdata),
        .pin_sel (pin_sel),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    assign data_bus = rd_drive ? rdata : {DW{1'bz}};
    assign pin_io   = pin_oe ? pin_out : 1'bz;

    // R11: the data bus is driven only under an acknowledge.
    a_r11_drive_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> ack);
endmodule

// File: tb/sfr_bus_slave_tb.sv
// Self-checking bench: directed corner cases plus seeded random accesses,
// checked against a register model kept in the bench.
module sfr_bus_slave_tb;
    localparam logic [7:0] CA = 8'h98;
    localparam logic [7:0] DA = 8'h99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr_bus = '0;
    logic       indirect_sel = 1'b0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0;
    logic       ack, pin_sel;
    wire  [7:0] data_bus;
    wire        pin_io;
    logic [7:0] tb_data = '0;
    logic       tb_data_en = 1'b0;
    logic       tb_pin = 1'b0;
    logic [6:0] ctrl_m = '0;
    logic [7:0] data_m = '0;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign data_bus = tb_data_en ? tb_data : 8'hzz;
    assign pin_io   = (ctrl_m[1] && ctrl_m[0]) ? 1'bz : tb_pin;

    sfr_bus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .addr_bus(addr_bus), .indirect_sel(indirect_sel),
        .data_bus(data_bus), .rd_stb(rd_stb), .wr_stb(wr_stb), .ack(ack),
        .pin_sel(pin_sel), .pin_io(pin_io)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic bit is_hit(input logic [7:0] a, input logic ind);
        return !ind && (a == CA || a == DA);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        logic lvl;
        lvl = (ctrl_m[1] && ctrl_m[0]) ? data_m[0] : tb_pin;
        return (a == DA) ? data_m : {lvl, ctrl_m};
    endfunction

    // Write access, optionally changing the bus value while the strobe is held.
    task automatic do_write(input logic [7:0] a, input logic ind, input logic [7:0] d,
                            input int hold, input string req);
        bit hit;
        hit = is_hit(a, ind);
        @(posedge clk); #1;
        addr_bus = a; indirect_sel = ind; tb_data = d; tb_data_en = 1'b1; wr_stb = 1'b1;
        if (hit) begin
            if (a == CA) ctrl_m = d[6:0];
            else         data_m = d;
        end
        @(posedge clk); #2;
        check(ack == hit, req, {7'd0, ack}, {7'd0, hit});
        tb_data = ~d;
        for (int i = 0; i < hold; i++) @(posedge clk);
        #1; wr_stb = 1'b0;
        @(posedge clk); #2;
        check(ack == 1'b0, "R4", {7'd0, ack}, 8'd0);
        tb_data_en = 1'b0;
    endtask

    // Read access; checks ack, returned value and bus release.
    task automatic do_read(input logic [7:0] a, input logic ind, input string req);
        bit hit;
        logic [7:0] exp;
        hit = is_hit(a, ind);
        exp = exp_read(a);
        @(posedge clk); #1;
        addr_bus = a; indirect_sel = ind; tb_data_en = 1'b0; rd_stb = 1'b1;
        @(posedge clk); #2;
        check(ack == hit, req, {7'd0, ack}, {7'd0, hit});
        if (hit) begin
            check(data_bus == exp, req, data_bus, exp);
        end else begin
            tb_data = 8'hC3; tb_data_en = 1'b1; #1;
            check(data_bus == 8'hC3, "R11", data_bus, 8'hC3);
            tb_data_en = 1'b0;
        end
        @(posedge clk); #2;
        check(ack == hit, "R4", {7'd0, ack}, {7'd0, hit});
        rd_stb = 1'b0;
        @(posedge clk); #2;
        check(ack == 1'b0, "R4", {7'd0, ack}, 8'd0);
        tb_data = ~exp; tb_data_en = 1'b1; #1;
        check(data_bus == ~exp, "R11", data_bus, ~exp);
        tb_data_en = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(posedge clk); #1; tb_pin = v;
        @(posedge clk); @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        check(ack == 1'b0, "R1", {7'd0, ack}, 8'd0);
        check(pin_sel == 1'b0, "R1", {7'd0, pin_sel}, 8'd0);
        #1; rst_n = 1'b1;
        do_read(CA, 1'b0, "R1");
        do_read(DA, 1'b0, "R1");

        // R2/R3 basic write then read back.
        do_write(DA, 1'b0, 8'h5A, 0, "R2");
        do_read(DA, 1'b0, "R3");
        do_write(CA, 1'b0, 8'h3C, 0, "R2");
        do_read(CA, 1'b0, "R3");

        // R5: held strobe with the bus changing stores only the first value.
        do_write(DA, 1'b0, 8'hA7, 3, "R5");
        do_read(DA, 1'b0, "R5");

        // R6 and R7: misses leave registers intact.
        do_write(8'h9A, 1'b0, 8'hFF, 0, "R6");
        do_write(DA, 1'b1, 8'h11, 0, "R7");
        do_write(CA, 1'b1, 8'h03, 0, "R7");
        do_read(8'h97, 1'b0, "R6");
        do_read(DA, 1'b1, "R7");
        do_read(DA, 1'b0, "R7");
        do_read(CA, 1'b0, "R6");

        // R10: bit 7 is read-only and follows the pin.
        do_write(CA, 1'b0, 8'h80, 0, "R10");
        set_pin(1'b0);
        do_read(CA, 1'b0, "R10");
        set_pin(1'b1);
        do_read(CA, 1'b0, "R10");

        // R8/R9: select alone keeps the pin floating; select plus enable drives it.
        do_write(CA, 1'b0, 8'h01, 0, "R8");
        #1;
        check(pin_sel == 1'b1, "R8", {7'd0, pin_sel}, 8'd1);
        set_pin(1'b0);
        check(pin_io == 1'b0, "R9", {7'd0, pin_io}, 8'd0);
        do_read(CA, 1'b0, "R9");
        do_write(DA, 1'b0, 8'h01, 0, "R9");
        do_write(CA, 1'b0, 8'h03, 0, "R9");
        @(posedge clk); #2;
        check(pin_io == 1'b1, "R9", {7'd0, pin_io}, 8'd1);
        do_read(CA, 1'b0, "R10");
        do_write(DA, 1'b0, 8'h00, 0, "R9");
        @(posedge clk); #2;
        check(pin_io == 1'b0, "R9", {7'd0, pin_io}, 8'd0);
        do_write(CA, 1'b0, 8'h02, 0, "R8");
        #1;
        check(pin_sel == 1'b0, "R8", {7'd0, pin_sel}, 8'd0);

        // Random mix of accesses against the model (R2, R3, R6, R7).
        for (int n = 0; n < 60; n++) begin
            logic [7:0] a;
            logic       ind;
            int         k;
            k = $urandom_range(0, 3);
            a = (k == 0) ? CA : (k == 1) ? DA : (8'h80 | 8'($urandom_range(0, 127)));
            ind = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 1) == 1) do_write(a, ind, 8'($urandom), $urandom_range(0, 2), "R2");
            else                           do_read(a, ind, "R3");
            if (n % 10 == 0) set_pin(1'($urandom));
        end
        do_read(CA, 1'b0, "R3");
        do_read(DA, 1'b0, "R3");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule